// File: doc/BRIEF.md
# Oversampled Bipolar Line Clock and Data Recovery

This block takes a bipolar (AMI) line as two already-sliced pulse indications, one for positive marks and one for negative marks. Both are sampled by a local clock that runs at sixteen times the nominal bit rate, so each bit interval spans sixteen samples. The block finds the leading edge of every mark and keeps a four-bit bit-phase counter aligned to those edges. At mid-bit it emits one recovered bit, along with a flag for a bipolar violation. A line may carry zero-substitution codes, so violations are reported and never corrected.

The recovered bit clock is a one-cycle enable in the oversampling clock domain, so everything downstream stays synchronous. If the line shows no marks for a long stretch, a carrier-loss flag rises and the output clock enable switches to a divide-by-sixteen of the local clock. The first mark after that clears the flag and returns the output to the recovered timing.

The recovered-bit output is a stream with a valid strobe and no ready. The line cannot be stalled, so there is no back-pressure: a consumer must accept every word in the cycle its valid is high, or the word is lost.

Top module: `line_cdr_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, every output is 0.
- R2: A mark is a 0-to-1 transition of (pos OR neg) taken from two register stages of the inputs. A pulse held high for many samples is one mark only.
- R3: The phase counter counts 0 to 15 and wraps. A mark seen at phase 0 leaves the normal step of +1. A mark at phase 1 to 7 holds the counter for that cycle. A mark at phase 8 to 15 steps the counter by +2.
- R4: `bit_valid_o` is a single-cycle pulse. It is high in the cycle after the phase counter reads 8.
- R5: `bit_data_o` is 1 when `bit_valid_o` is high and a mark was seen since the previous strobe, including the strobe cycle itself. Otherwise it is 0.
- R6: `bit_bpv_o` is 1 with a valid bit whose mark has the same polarity as the previous mark. A mark on both inputs at once counts as positive. The first mark after reset is never a violation.
- R7: `carrier_lost_o` rises in the cycle after the 192nd consecutive strobe without a mark.
- R8: `carrier_lost_o` falls in the cycle after the first mark edge.
- R9: `clk_en_o` follows `bit_valid_o` in the cycle after `carrier_lost_o` was low. In the cycle after `carrier_lost_o` was high, it pulses once every 16 cycles from a free-running divider that counts from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, 16x the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_pos_i | input | 1 | Positive pulse indication from the slicer |
| line_neg_i | input | 1 | Negative pulse indication from the slicer |
| bit_valid_o | output | 1 | One-cycle strobe of a recovered bit |
| bit_data_o | output | 1 | Recovered NRZ bit, valid with the strobe |
| bit_bpv_o | output | 1 | Bipolar violation on this bit |
| carrier_lost_o | output | 1 | No line activity for 192 bit periods |
| clk_en_o | output | 1 | Output bit clock enable, recovered or local |

## Verification
Alternating marks at exactly sixteen samples per bit show whether the counter stays locked without drift. Streams at fifteen and seventeen samples per bit, and a stream broken by a few idle samples, separate the hold step from the skip step of the counter. Repeated polarity and both-input pulses separate real violations from legal alternation and test the positive-wins rule. A long held pulse shows that level does not make repeated marks. A long run of zeros followed by new marks exercises carrier loss and the return of the clock from the local divider to the recovered strobe.

// File: rtl/line_cdr_pkg.sv
package line_cdr_pkg;
  typedef struct packed {
    logic valid;
    logic data;
    logic bpv;
  } cdr_bit_t;
endpackage

// File: rtl/cdr_edge_det.sv
module cdr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pos_i,
  input  logic neg_i,
  output logic mark_edge_o,
  output logic mark_pos_o
);
  logic [1:0] raw;
  logic [1:0] stg1;
  logic [1:0] stg2;

  assign raw = {neg_i, pos_i};

  // one synchronising pair per polarity lane
  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg1[g] <= 1'b0;
        stg2[g] <= 1'b0;
      end else begin
        stg1[g] <= raw[g];
        stg2[g] <= stg1[g];
      end
    end
  end

  assign mark_edge_o = (|stg1) & ~(|stg2);
  assign mark_pos_o  = stg1[0];

  p_edge_new_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mark_edge_o |=> !mark_edge_o);
endmodule

// File: rtl/cdr_phase_track.sv
module cdr_phase_track #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mark_edge_i,
  output logic strobe_o
);
  localparam int PW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  logic [PW-1:0] ph_q;
  logic [PW-1:0] ph_d;
  logic          early;
  logic          late;

  assign early = mark_edge_i && (ph_q != '0) && (ph_q < PW'(MID));
  assign late  = mark_edge_i && (ph_q >= PW'(MID));

  always_comb begin
    if (early)     ph_d = ph_q;
    else if (late) ph_d = ph_q + PW'(2);
    else           ph_d = ph_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign strobe_o = (ph_q == PW'(MID));

  p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mark_edge_i |=> (ph_q == PW'($past(ph_q) + PW'(1))));
  p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mark_edge_i |=> (PW'(ph_q - $past(ph_q)) <= PW'(2)));
endmodule

// File: rtl/cdr_ami_decode.sv
module cdr_ami_decode
  import line_cdr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mark_edge_i,
  input  logic     mark_pos_i,
  input  logic     strobe_i,
  output logic     mark_now_o,
  output cdr_bit_t bit_o
);
  logic hold_q;
  logic hold_pos_q;
  logic seen_q;
  logic last_pos_q;
  logic pol_now;
  logic viol;

  assign mark_now_o = hold_q | mark_edge_i;
  assign pol_now    = mark_edge_i ? mark_pos_i : hold_pos_q;
  assign viol       = mark_now_o & seen_q & (pol_now == last_pos_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      hold_pos_q <= 1'b0;
      seen_q     <= 1'b0;
      last_pos_q <= 1'b0;
      bit_o      <= '0;
    end else begin
      bit_o.valid <= strobe_i;
      bit_o.data  <= strobe_i & mark_now_o;
      bit_o.bpv   <= strobe_i & viol;
      if (strobe_i) begin
        hold_q <= 1'b0;
        if (mark_now_o) begin
          seen_q     <= 1'b1;
          last_pos_q <= pol_now;
        end
      end else if (mark_edge_i) begin
        hold_q     <= 1'b1;
        hold_pos_q <= mark_pos_i;
      end
    end
  end

  p_bpv_is_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_o.bpv |-> (bit_o.data && bit_o.valid));
  p_data_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_o.valid |-> !bit_o.data);
  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_o.valid |=> !bit_o.valid);
endmodule

// File: rtl/cdr_loss_mon.sv
module cdr_loss_mon #(
  parameter int OSR      = 16,
  parameter int LOS_BITS = 192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mark_edge_i,
  input  logic mark_now_i,
  input  logic strobe_i,
  output logic lost_o,
  output logic clk_en_o
);
  localparam int PW = $clog2(OSR);
  localparam int IW = $clog2(LOS_BITS + 1);

  logic [IW-1:0] idle_q;
  logic [IW:0]   idle_inc;
  logic [PW-1:0] ref_q;
  logic          ref_tick;
  logic          hit_limit;

  assign idle_inc  = {1'b0, idle_q} + (IW+1)'(1);
  assign hit_limit = idle_inc >= (IW+1)'(LOS_BITS);
  assign ref_tick  = (ref_q == PW'(OSR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q   <= '0;
      ref_q    <= '0;
      lost_o   <= 1'b0;
      clk_en_o <= 1'b0;
    end else begin
      ref_q    <= ref_q + PW'(1);
      clk_en_o <= lost_o ? ref_tick : strobe_i;
      if (strobe_i) begin
        if (mark_now_i)     idle_q <= '0;
        else if (!hit_limit) idle_q <= idle_inc[IW-1:0];
        else                 idle_q <= IW'(LOS_BITS);
      end
      if (mark_edge_i)
        lost_o <= 1'b0;
      else if (strobe_i && !mark_now_i && hit_limit)
        lost_o <= 1'b1;
    end
  end

  p_los_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_o && mark_edge_i) |=> !lost_o);
  p_los_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_o) |-> ($past(strobe_i) && !$past(mark_now_i)));
endmodule

// File: rtl/line_cdr_top.sv
module line_cdr_top
  import line_cdr_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int LOS_BITS = 192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_pos_i,
  input  logic line_neg_i,
  output logic bit_valid_o,
  output logic bit_data_o,
  output logic bit_bpv_o,
  output logic carrier_lost_o,
  output logic clk_en_o
);
  logic     mark_edge;
  logic     mark_pos;
  logic     strobe;
  logic     mark_now;
  cdr_bit_t rbit;

  cdr_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .pos_i(line_pos_i), .neg_i(line_neg_i),
    .mark_edge_o(mark_edge), .mark_pos_o(mark_pos));

  cdr_phase_track #(.OSR(OSR)) u_phase (
    .clk(clk), .rst_n(rst_n), .mark_edge_i(mark_edge), .strobe_o(strobe));

  cdr_ami_decode u_dec (
    .clk(clk), .rst_n(rst_n), .mark_edge_i(mark_edge), .mark_pos_i(mark_pos),
    .strobe_i(strobe), .mark_now_o(mark_now), .bit_o(rbit));

  cdr_loss_mon #(.OSR(OSR), .LOS_BITS(LOS_BITS)) u_los (
    .clk(clk), .rst_n(rst_n), .mark_edge_i(mark_edge), .mark_now_i(mark_now),
    .strobe_i(strobe), .lost_o(carrier_lost_o), .clk_en_o(clk_en_o));

  assign bit_valid_o = rbit.valid;
  assign bit_data_o  = rbit.data;
  assign bit_bpv_o   = rbit.bpv;

  p_clk_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier_lost_o |=> (clk_en_o == bit_valid_o));
endmodule

// File: tb/tb_line_cdr_top.sv
module tb_line_cdr_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_pos_i = 1'b0;
  logic line_neg_i = 1'b0;
  logic bit_valid_o, bit_data_o, bit_bpv_o, carrier_lost_o, clk_en_o;

  int checks = 0;
  int failures = 0;
  bit cmp_on = 1'b0;
  bit seen_los = 1'b0, seen_bpv = 1'b0, seen_clear = 1'b0;

  // behavioural reference state
  int m_s_pos = 0, m_s_neg = 0, m_d_pos = 0, m_d_neg = 0;
  int m_ph = 0, m_hold = 0, m_hpol = 0, m_seen = 0, m_last = 0;
  int m_idle = 0, m_los = 0, m_ref = 0;
  int m_valid = 0, m_data = 0, m_bpv = 0, m_clken = 0;

  line_cdr_top dut (
    .clk(clk), .rst_n(rst_n), .line_pos_i(line_pos_i), .line_neg_i(line_neg_i),
    .bit_valid_o(bit_valid_o), .bit_data_o(bit_data_o), .bit_bpv_o(bit_bpv_o),
    .carrier_lost_o(carrier_lost_o), .clk_en_o(clk_en_o));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    int edge_n, strobe, mark, pnow;
    if (!rst_n) begin
      m_s_pos = 0; m_s_neg = 0; m_d_pos = 0; m_d_neg = 0;
      m_ph = 0; m_hold = 0; m_hpol = 0; m_seen = 0; m_last = 0;
      m_idle = 0; m_los = 0; m_ref = 0;
      m_valid = 0; m_data = 0; m_bpv = 0; m_clken = 0;
    end else begin
      edge_n = ((m_s_pos | m_s_neg) != 0 && (m_d_pos | m_d_neg) == 0) ? 1 : 0;
      strobe = (m_ph == 8) ? 1 : 0;
      mark   = (m_hold != 0 || edge_n != 0) ? 1 : 0;
      pnow   = edge_n ? m_s_pos : m_hpol;
      m_valid = strobe;
      m_data  = strobe & mark;
      m_bpv   = (strobe && mark && m_seen && pnow == m_last) ? 1 : 0;
      m_clken = m_los ? (m_ref == 15 ? 1 : 0) : strobe;
      if (edge_n) m_los = 0;
      else if (strobe && !mark && m_idle + 1 >= 192) m_los = 1;
      if (strobe) m_idle = mark ? 0 : ((m_idle + 1 > 192) ? 192 : m_idle + 1);
      if (strobe) begin
        m_hold = 0;
        if (mark) begin m_seen = 1; m_last = pnow; end
      end else if (edge_n) begin
        m_hold = 1; m_hpol = m_s_pos;
      end
      if (edge_n && m_ph >= 1 && m_ph <= 7) m_ph = m_ph;
      else if (edge_n && m_ph >= 8) m_ph = (m_ph + 2) % 16;
      else m_ph = (m_ph + 1) % 16;
      m_ref = (m_ref + 1) % 16;
      m_d_pos = m_s_pos; m_d_neg = m_s_neg;
      m_s_pos = line_pos_i; m_s_neg = line_neg_i;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(bit_valid_o == m_valid, "R3 R4 bit_valid", bit_valid_o, m_valid);
      chk(bit_data_o == m_data, "R2 R5 bit_data", bit_data_o, m_data);
      chk(bit_bpv_o == m_bpv, "R6 bit_bpv", bit_bpv_o, m_bpv);
      chk(carrier_lost_o == m_los, "R7 R8 carrier_lost", carrier_lost_o, m_los);
      chk(clk_en_o == m_clken, "R9 clk_en", clk_en_o, m_clken);
      if (bit_bpv_o) seen_bpv = 1'b1;
      if (carrier_lost_o) seen_los = 1'b1;
      if (seen_los && !carrier_lost_o) seen_clear = 1'b1;
    end
  end

  // pol: 1 positive, 0 negative, 2 both
  task automatic send_bit(input int mark, input int pol, input int period);
    for (int i = 0; i < period; i++) begin
      @(negedge clk);
      line_pos_i = (mark != 0 && i < period / 2 && pol != 0);
      line_neg_i = (mark != 0 && i < period / 2 && pol != 1);
    end
  endtask

  task automatic send_ami(input int nbits, input int period, input int ones_every);
    int pol = 1;
    for (int b = 0; b < nbits; b++) begin
      if (b % ones_every == 0) begin
        send_bit(1, pol, period);
        pol = 1 - pol;
      end else send_bit(0, 0, period);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    cmp_on = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(bit_valid_o == 0 && bit_data_o == 0 && bit_bpv_o == 0, "R1 reset outputs",
        {bit_valid_o, bit_data_o, bit_bpv_o}, 0);
    chk(carrier_lost_o == 0 && clk_en_o == 0, "R1 reset status",
        {carrier_lost_o, clk_en_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bit_valid_o == 0 && clk_en_o == 0, "R1 first cycle", bit_valid_o, 0);
    send_ami(40, 16, 1);            // R3 locked alternation
    send_ami(40, 15, 1);            // R3 fast line
    send_ami(40, 17, 2);            // R3 slow line, sparse marks
    repeat (5) @(negedge clk);      // R3 phase jump
    send_ami(20, 16, 1);
    for (int k = 0; k < 6; k++) send_bit(1, 1, 16);   // R6 repeated positive
    for (int k = 0; k < 4; k++) send_bit(1, 2, 16);   // R6 both inputs
    send_bit(1, 0, 16);
    @(negedge clk); line_pos_i = 1'b1;               // R2 long held pulse
    repeat (60) @(negedge clk); line_pos_i = 1'b0;
    send_ami(10, 16, 1);
    for (int k = 0; k < 200; k++) send_bit(0, 0, 16); // R7 zeros
    send_ami(30, 16, 1);                              // R8 recovery
    repeat (40) @(negedge clk);
    chk(seen_bpv, "R6 violation observed", seen_bpv, 1);
    chk(seen_los, "R7 carrier loss observed", seen_los, 1);
    chk(seen_clear, "R8 carrier loss cleared", seen_clear, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule